// File: doc/BRIEF.md
# Add-Subtract Unit with Selectable Carry Convention

This block is the add and subtract datapath of a small processor core. It adds two bytes with an incoming carry, or subtracts one byte from another with an incoming borrow. It holds one carry flag together with zero, negative and overflow flags. The result is combinational, and the flags are registered.

A build-time parameter sets what the carry flag means during subtraction. In the inverted-borrow convention, a subtract adds the complemented operand plus the carry flag, and writes back the raw adder carry-out. A set flag therefore means "no borrow". In the true-borrow convention, the flag holds the borrow itself. Because a cleared flag then means "no carry" for an add and "no borrow" for a subtract, one clear-carry command prepares either kind of multi-byte chain.

The block provides a clear-carry command and deliberately has no set-carry command.

Top module: `addsub_cc_unit`

## Requirements
- R1: With `op_sub`=0, `result` equals (`op_a` + `op_b` + C) mod 256, where C is the carry flag currently shown on `carry_o`.
- R2: An add with `flag_we`=1 and `clr_carry`=0 stores bit 8 of `op_a`+`op_b`+C in the carry flag at the clock edge, in both conventions.
- R3: Inverted-borrow convention (`CONV`=0), `op_sub`=1: `result` = (`op_a` − `op_b` − 1 + C) mod 256. The stored carry is 1 exactly when `op_a` + C ≥ `op_b` + 1, so a subtract with C=0 gives `op_a` − `op_b` − 1.
- R4: True-borrow convention (`CONV`=1), `op_sub`=1: `result` = (`op_a` − `op_b` − C) mod 256. The stored carry is 1 exactly when `op_a` < `op_b` + C.
- R5: On a flag write, zero is set exactly when all result bits are 0, and negative takes result bit 7.
- R6: On a flag write, overflow is set when `op_a` and the adder's second input have equal sign bits and the result sign differs from them. The adder's second input is `op_b` for an add and ~`op_b` for a subtract. This equals two's-complement overflow of the signed operation.
- R7: When `flag_we`=0 and `clr_carry`=0 at a clock edge, all four flags keep their values.
- R8: `clr_carry`=1 clears the carry flag at the clock edge. It overrides a simultaneous flag write for the carry only; zero, negative and overflow still follow `flag_we`.
- R9: Synchronous active-high `rst` clears all four flags.
- R10: A byte-serial subtract chain, least significant byte first, reproduces the wide difference and its final borrow indication. In the true-borrow convention the chain starts from a cleared carry; in the inverted-borrow convention it starts from a set carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the flags |
| op_a | input | 8 | First operand (minuend for subtract) |
| op_b | input | 8 | Second operand (subtrahend for subtract) |
| op_sub | input | 1 | 1 selects subtract-with-carry, 0 selects add-with-carry |
| flag_we | input | 1 | Stores new flags at the clock edge |
| clr_carry | input | 1 | Clears the carry flag at the clock edge |
| result | output | 8 | Combinational arithmetic result |
| carry_o | output | 1 | Carry flag (its meaning on subtract depends on `CONV`) |
| zero_o | output | 1 | Zero flag |
| neg_o | output | 1 | Negative flag |
| ovf_o | output | 1 | Signed overflow flag |

## Verification
The assertions assume that `op_a`, `op_b` and `op_sub` are settled and known at every clock edge once reset is released. They also assume that the carry flag seen at an edge is the one the arithmetic consumed in that cycle. The bench keeps to this by changing inputs only on falling edges and holding `rst` high from time zero. Known carry values are set up only through the block's own commands: a clear, optionally followed by an add of 0xFF and 0x01. The stimulus therefore never relies on a set-carry path, which the block does not have.

// File: rtl/addsub_cc_pkg.sv
package addsub_cc_pkg;

  // How the carry flag is interpreted on subtract.
  typedef enum logic {
    CONV_INV_BORROW  = 1'b0,  // flag = not-borrow, raw adder carry used
    CONV_TRUE_BORROW = 1'b1   // flag = borrow, inverted on both sides
  } carry_conv_e;

  typedef struct packed {
    logic c;
    logic z;
    logic n;
    logic v;
  } flag_set_t;

endpackage

// File: rtl/addsub_operand_cond.sv
module addsub_operand_cond
  import addsub_cc_pkg::*;
#(
  parameter int          W    = 8,
  parameter carry_conv_e CONV = CONV_TRUE_BORROW
) (
  input  logic [W-1:0] b_in,
  input  logic         sub,
  input  logic         c_flag,
  output logic [W-1:0] b_eff,
  output logic         c_in
);

  // Subtract is performed as addition of the one's complement.
  assign b_eff = sub ? ~b_in : b_in;

  generate
    if (CONV == CONV_TRUE_BORROW) begin : g_true_borrow
      // The flag holds a borrow: the adder needs its complement.
      assign c_in = sub ? ~c_flag : c_flag;
    end else begin : g_inv_borrow
      // The flag already holds not-borrow: it feeds the adder directly.
      assign c_in = c_flag;
    end
  endgenerate

endmodule

// File: rtl/addsub_ripple_adder.sv
module addsub_ripple_adder #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);

  logic [W:0] cy;

  assign cy[0] = cin;

  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_bit
      logic p;
      assign p         = a[i] ^ b[i];
      assign sum[i]    = p ^ cy[i];
      assign cy[i+1]   = (a[i] & b[i]) | (cy[i] & p);
    end
  endgenerate

  assign cout = cy[W];

endmodule

// File: rtl/addsub_flag_eval.sv
module addsub_flag_eval
  import addsub_cc_pkg::*;
#(
  parameter int          W    = 8,
  parameter carry_conv_e CONV = CONV_TRUE_BORROW
) (
  input  logic         sub,
  input  logic         a_msb,
  input  logic         b_eff_msb,
  input  logic [W-1:0] sum,
  input  logic         cout,
  output flag_set_t    nxt
);

  generate
    if (CONV == CONV_TRUE_BORROW) begin : g_true_borrow
      assign nxt.c = sub ? ~cout : cout;
    end else begin : g_inv_borrow
      assign nxt.c = cout;
    end
  endgenerate

  assign nxt.z = ~|sum;
  assign nxt.n = sum[W-1];
  assign nxt.v = (a_msb == b_eff_msb) && (sum[W-1] != a_msb);

endmodule

// File: rtl/addsub_flag_reg.sv
module addsub_flag_reg
  import addsub_cc_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      flag_we,
  input  logic      clr_carry,
  input  flag_set_t nxt,
  output flag_set_t flags
);

  always_ff @(posedge clk) begin
    if (rst) begin
      flags <= '0;
    end else begin
      if (flag_we) begin
        flags <= nxt;
      end
      if (clr_carry) begin
        flags.c <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/addsub_cc_unit.sv
module addsub_cc_unit
  import addsub_cc_pkg::*;
#(
  parameter int          W    = 8,
  parameter carry_conv_e CONV = CONV_TRUE_BORROW
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic         op_sub,
  input  logic         flag_we,
  input  logic         clr_carry,
  output logic [W-1:0] result,
  output logic         carry_o,
  output logic         zero_o,
  output logic         neg_o,
  output logic         ovf_o
);

  logic [W-1:0] b_eff;
  logic         c_in;
  logic [W-1:0] sum;
  logic         cout;
  flag_set_t    nxt;
  flag_set_t    flags;

  addsub_operand_cond #(.W(W), .CONV(CONV)) u_cond (
    .b_in   (op_b),
    .sub    (op_sub),
    .c_flag (flags.c),
    .b_eff  (b_eff),
    .c_in   (c_in)
  );

  addsub_ripple_adder #(.W(W)) u_add (
    .a    (op_a),
    .b    (b_eff),
    .cin  (c_in),
    .sum  (sum),
    .cout (cout)
  );

  addsub_flag_eval #(.W(W), .CONV(CONV)) u_eval (
    .sub       (op_sub),
    .a_msb     (op_a[W-1]),
    .b_eff_msb (b_eff[W-1]),
    .sum       (sum),
    .cout      (cout),
    .nxt       (nxt)
  );

  addsub_flag_reg u_flags (
    .clk       (clk),
    .rst       (rst),
    .flag_we   (flag_we),
    .clr_carry (clr_carry),
    .nxt       (nxt),
    .flags     (flags)
  );

  assign result  = sum;
  assign carry_o = flags.c;
  assign zero_o  = flags.z;
  assign neg_o   = flags.n;
  assign ovf_o   = flags.v;

endmodule

// File: rtl/addsub_cc_chk.sv
module addsub_cc_chk
  import addsub_cc_pkg::*;
#(
  parameter int          W    = 8,
  parameter carry_conv_e CONV = CONV_TRUE_BORROW
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] op_a,
  input logic [W-1:0] op_b,
  input logic         op_sub,
  input logic         flag_we,
  input logic         clr_carry,
  input logic [W-1:0] result,
  input logic         carry_o,
  input logic         zero_o,
  input logic         neg_o,
  input logic         ovf_o
);

  logic [W:0]   add_wide;
  logic [W-1:0] sub_exp;
  logic         sub_flag_exp;
  logic [W:0]   b_plus_c;
  logic [W:0]   b_plus_nc;

  assign add_wide  = {1'b0, op_a} + {1'b0, op_b} + {{W{1'b0}}, carry_o};
  assign b_plus_c  = {1'b0, op_b} + {{W{1'b0}}, carry_o};
  assign b_plus_nc = {1'b0, op_b} + {{W{1'b0}}, ~carry_o};

  generate
    if (CONV == CONV_TRUE_BORROW) begin : g_exp_true
      assign sub_exp      = op_a - op_b - {{(W-1){1'b0}}, carry_o};
      assign sub_flag_exp = {1'b0, op_a} < b_plus_c;
    end else begin : g_exp_inv
      assign sub_exp      = op_a - op_b - {{(W-1){1'b0}}, ~carry_o};
      assign sub_flag_exp = {1'b0, op_a} >= b_plus_nc;
    end
  endgenerate

  // R1
  add_result_chk: assert property (@(posedge clk) disable iff (rst)
    !op_sub |-> result == add_wide[W-1:0]);

  // R2
  add_carry_chk: assert property (@(posedge clk) disable iff (rst)
    (flag_we && !clr_carry && !op_sub) |=> carry_o == $past(add_wide[W]));

  // R3 R4
  sub_result_chk: assert property (@(posedge clk) disable iff (rst)
    op_sub |-> result == sub_exp);

  // R3 R4
  sub_carry_chk: assert property (@(posedge clk) disable iff (rst)
    (flag_we && !clr_carry && op_sub) |=> carry_o == $past(sub_flag_exp));

  // R5
  zero_neg_chk: assert property (@(posedge clk) disable iff (rst)
    flag_we |=> (zero_o == ($past(result) == '0)) && (neg_o == $past(result[W-1])));

  // R7
  hold_flags_chk: assert property (@(posedge clk) disable iff (rst)
    (!flag_we && !clr_carry) |=> $stable({carry_o, zero_o, neg_o, ovf_o}));

  // R8
  clear_carry_chk: assert property (@(posedge clk) disable iff (rst)
    clr_carry |=> !carry_o);

  // R9
  reset_flags_chk: assert property (@(posedge clk)
    rst |=> {carry_o, zero_o, neg_o, ovf_o} == 4'b0000);

endmodule

bind addsub_cc_unit addsub_cc_chk #(.W(W), .CONV(CONV)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .op_a      (op_a),
  .op_b      (op_b),
  .op_sub    (op_sub),
  .flag_we   (flag_we),
  .clr_carry (clr_carry),
  .result    (result),
  .carry_o   (carry_o),
  .zero_o    (zero_o),
  .neg_o     (neg_o),
  .ovf_o     (ovf_o)
);

// File: tb/test_addsub_cc_unit.sv
`timescale 1ns/1ps
module test_addsub_cc_unit;
  import addsub_cc_pkg::*;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] a = '0, b = '0;
  logic       sub = 1'b0, we = 1'b0, clr = 1'b0;

  // true-borrow instance
  logic [7:0] r_t;
  logic       c_t, z_t, n_t, v_t;
  // inverted-borrow instance
  logic [7:0] r_i;
  logic       c_i, z_i, n_i, v_i;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  addsub_cc_unit #(.W(8), .CONV(CONV_TRUE_BORROW)) i_addsub_cc_unit (
    .clk(clk), .rst(rst), .op_a(a), .op_b(b), .op_sub(sub),
    .flag_we(we), .clr_carry(clr),
    .result(r_t), .carry_o(c_t), .zero_o(z_t), .neg_o(n_t), .ovf_o(v_t));

  addsub_cc_unit #(.W(8), .CONV(CONV_INV_BORROW)) i_addsub_cc_unit_inv (
    .clk(clk), .rst(rst), .op_a(a), .op_b(b), .op_sub(sub),
    .flag_we(we), .clr_carry(clr),
    .result(r_i), .carry_o(c_i), .zero_o(z_i), .neg_o(n_i), .ovf_o(v_i));

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d (a=%0d b=%0d sub=%0d)",
               tag, act, exp, a, b, sub);
    end
  endtask

  function automatic int sgn(input int x);
    return (x > 127) ? x - 256 : x;
  endfunction

  // Leaves both instances with carry = c, using only clear and an add.
  task automatic set_carry(input bit c);
    clr = 1'b1; we = 1'b0;
    @(negedge clk);
    clr = 1'b0;
    if (c) begin
      a = 8'hFF; b = 8'h01; sub = 1'b0; we = 1'b1;
      @(negedge clk);
      we = 1'b0;
    end
  endtask

  task automatic run_case(input int xa, input int xb, input bit xs, input bit c);
    int er_t, er_i, ec_t, ec_i, sd_t, sd_i, ev_t, ev_i;
    set_carry(c);
    a = 8'(xa); b = 8'(xb); sub = xs; we = 1'b1;
    if (!xs) begin
      er_t = (xa + xb + c) & 255;  ec_t = (xa + xb + c) > 255;
      sd_t = sgn(xa) + sgn(xb) + c;
      er_i = er_t; ec_i = ec_t; sd_i = sd_t;
    end else begin
      er_t = (xa - xb - c) & 255;  ec_t = (xa < xb + c);
      sd_t = sgn(xa) - sgn(xb) - c;
      er_i = (xa - xb - 1 + c) & 255; ec_i = (xa + c >= xb + 1);
      sd_i = sgn(xa) - sgn(xb) - 1 + c;
    end
    ev_t = (sd_t < -128 || sd_t > 127);
    ev_i = (sd_i < -128 || sd_i > 127);
    #1;
    chk(xs ? "R4 result" : "R1 result true-borrow", r_t, er_t);
    chk(xs ? "R3 result" : "R1 result inv-borrow",  r_i, er_i);
    @(negedge clk);
    we = 1'b0;
    chk(xs ? "R4 carry" : "R2 carry true-borrow", c_t, ec_t);
    chk(xs ? "R3 carry" : "R2 carry inv-borrow",  c_i, ec_i);
    chk("R5 zero true-borrow", z_t, er_t == 0);
    chk("R5 zero inv-borrow",  z_i, er_i == 0);
    chk("R5 neg true-borrow",  n_t, er_t >> 7);
    chk("R5 neg inv-borrow",   n_i, er_i >> 7);
    chk("R6 ovf true-borrow",  v_t, ev_t);
    chk("R6 ovf inv-borrow",   v_i, ev_i);
  endtask

  // Four-byte subtract chain, least significant byte first.
  task automatic run_chain(input logic [31:0] x, input logic [31:0] y, input bit start_c);
    logic [31:0] got_t, got_i, ed;
    got_t = '0; got_i = '0;
    set_carry(start_c);
    for (int k = 0; k < 4; k++) begin
      a = x[8*k +: 8]; b = y[8*k +: 8]; sub = 1'b1; we = 1'b1;
      #1;
      got_t[8*k +: 8] = r_t;
      got_i[8*k +: 8] = r_i;
      @(negedge clk);
    end
    we = 1'b0;
    ed = x - y;
    if (!start_c) begin
      chk("R10 chain diff true-borrow", int'(got_t), int'(ed));
      chk("R10 chain borrow true-borrow", c_t, x < y);
    end else begin
      chk("R10 chain diff inv-borrow", int'(got_i), int'(ed));
      chk("R10 chain no-borrow inv-borrow", c_i, x >= y);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [3:0] held_t, held_i;
    repeat (3) @(negedge clk);
    // R9: flags cleared by reset (first make them nonzero, then reset)
    rst = 1'b0;
    a = 8'h80; b = 8'h80; sub = 1'b0; we = 1'b1;
    @(negedge clk);
    we = 1'b0; rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R9 reset flags true-borrow", {c_t, z_t, n_t, v_t}, 0);
    chk("R9 reset flags inv-borrow",  {c_i, z_i, n_i, v_i}, 0);

    // R8: clear overrides a simultaneous carry-producing write
    set_carry(1'b0);
    a = 8'hFF; b = 8'h01; sub = 1'b0; we = 1'b1; clr = 1'b1;
    @(negedge clk);
    we = 1'b0; clr = 1'b0;
    chk("R8 carry cleared true-borrow", c_t, 0);
    chk("R8 carry cleared inv-borrow",  c_i, 0);
    chk("R8 zero still written", z_t, 1);
    // R8: clear alone touches only carry
    set_carry(1'b1);
    a = 8'h7F; b = 8'h01; sub = 1'b0; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    chk("R8 clear only carry", {c_t, z_t, n_t, v_t}, 4'b0011);

    // R7: no write, no clear -> flags hold while inputs change
    held_t = {c_t, z_t, n_t, v_t};
    held_i = {c_i, z_i, n_i, v_i};
    for (int k = 0; k < 6; k++) begin
      a = 8'(k * 37); b = 8'(255 - k * 11); sub = k[0];
      @(negedge clk);
    end
    chk("R7 hold true-borrow", {c_t, z_t, n_t, v_t}, held_t);
    chk("R7 hold inv-borrow",  {c_i, z_i, n_i, v_i}, held_i);

    // R3 directed: subtract with carry clear in inverted mode gives a-b-1
    run_case(10, 3, 1'b1, 1'b0);
    run_case(0, 0, 1'b1, 1'b0);

    // R1..R6 sweep
    for (int xa = 0; xa < 256; xa++) begin
      for (int xb = 0; xb < 256; xb += 7) begin
        for (int xs = 0; xs < 2; xs++) begin
          for (int c = 0; c < 2; c++) begin
            run_case(xa, (xb + xa) & 255, xs[0], c[0]);
          end
        end
      end
    end

    // R10 chains
    run_chain(32'h1234_5678, 32'h0234_5679, 1'b0);
    run_chain(32'h1234_5678, 32'h0234_5679, 1'b1);
    run_chain(32'h0000_0000, 32'h0000_0001, 1'b0);
    run_chain(32'h0000_0000, 32'h0000_0001, 1'b1);
    run_chain(32'h8000_0000, 32'h7FFF_FFFF, 1'b0);
    run_chain(32'h8000_0000, 32'h7FFF_FFFF, 1'b1);
    run_chain(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0);
    run_chain(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule